// File: doc/BRIEF.md
# Probabilistic Spike Fan-out Router

This block turns spike events from source neurons into a stream of delivery packets for target neurons. Each weighted connection is a delivery probability, not a magnitude. A spike arrives on a valid/ready input and names its source by chip, row and column. The router uses that source index to read the source's connection list from an external weight memory with synchronous reads. The list is a fixed number of 32-bit entries, and each entry packs four 8-bit slots.

For every slot it examines, the router draws a fresh 7-bit pseudo-random number from an internal linear feedback shift register. It then runs a Bernoulli trial. The trial passes when the draw is below the slot's 6-bit magnitude with a zero bit placed above it, so no weight can deliver more than half of the spikes. Each pass produces a two-word packet on a valid/ready output. The packet carries the target's route, row and column, and the synapse type taken from the slot's sign. A control bit in a slot ends the walk early.

The output is paced so that consecutive words are at least a fixed number of cycles apart. This matches a slow downstream link. While a walk is in progress or a packet is stalled, the input is held off.

Top module: `spike_fanout_router`

## Requirements
- R1: `in_data` is `{chip, row, col}` and its value is the source index `s`. Entry `e` of that source is read at address `s*ENTRIES + e`. Entries are read in rising order, one read per entry. Read data is taken on the cycle after `mem_rd_en`.
- R2: Inside an entry, slot `k` occupies bits `[8k+7:8k]` and slots are examined from k=0 up to k=3. In a slot byte, bits [5:0] are the magnitude, bit 6 is the sign (1 = negative) and bit 7 is the end-of-list control bit.
- R3: The random source is a 16-bit register whose reset value is `LFSR_SEED`, or 1 when the seed is zero. One step is `s = {s[14:0], s[15]^s[13]^s[12]^s[10]}`. Each examined slot advances the register by 7 steps and uses bits [6:0] of the new state as its draw. The state is never all zeros.
- R4: A slot delivers only when draw < `{1'b0, magnitude}`. Magnitude 0 therefore never delivers, and magnitude 63 delivers at a rate near 63/128.
- R5: A delivery produces two output words, with `out_last` high on the second. Word 0 is the target route, zero-extended. Word 1 is `{type, trow, tcol}`. The target code is `t = (g*TGT_MUL + TGT_ADD) mod 2^(ROUTE_W+ROW_W+COL_W)`, where `g = address*4 + k`. From the top of `t` down, the fields are route, then `trow`, then `tcol`.
- R6: The type bit in word 1 equals the slot's sign bit: 0 for excitatory, 1 for inhibitory.
- R7: The walk ends after a slot whose control bit is set, and that slot's own trial is still run. Otherwise it ends after slot 3 of entry `ENTRIES-1`. No further reads follow the end.
- R8: `in_ready` is high only while no walk is in progress. It is low from the cycle after a spike is accepted until the last word of that walk has been taken.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` and `out_last` do not change.
- R10: Two consecutive output word handshakes are at least `WORD_CYC` cycles apart (4 by default).
- R11: During and right after reset, `in_ready` is 1, and `out_valid` and `mem_rd_en` are 0.
- R12: Packets leave in the order of their slots: by entry, then by slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Spike event present |
| in_ready | output | 1 | Router idle, accepts a spike |
| in_data | input | CHIP_W+ROW_W+COL_W | Source `{chip, row, col}` |
| mem_rd_en | output | 1 | Weight memory read strobe |
| mem_addr | output | SRC_W+log2(ENTRIES) | Weight memory word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | max(ROUTE_W, 1+ROW_W+COL_W) | Output word |
| out_last | output | 1 | Second (final) word of a packet |

## Verification
The assertions check the following on every cycle:
- the random state never collapses to zero;
- memory reads step through the entry offsets of the current source in rising order;
- `in_ready` drops once a spike is accepted;
- a stalled output word holds;
- handshakes keep the minimum word spacing.

Which slots deliver, what the packets contain, and where a walk stops can only be shown by the bench scenarios. The bench replays the random sequence in its own model over full sweeps of all sources with three back-pressure patterns. It adds lists built from zero weights, from saturated weights with alternating signs, and with early end marks. It also checks the delivery rate of the largest weight against its expected band.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int LFSR_W = 16;
  localparam int DRAW_W = 7;
  localparam int SLOT_W = 8;
  localparam int SLOTS  = 4;
  localparam int MAG_W  = 6;

  // slot byte: [7] end-of-list, [6] negative sign, [5:0] magnitude
  typedef struct packed {
    logic             stop;
    logic             neg;
    logic [MAG_W-1:0] mag;
  } slot_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_TRIAL,
    ST_EMIT
  } walk_st_e;

  // one shift of the 16-bit maximal-length register
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // DRAW_W shifts, so every draw is made of fresh bits
  function automatic logic [LFSR_W-1:0] lfsr_jump(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < DRAW_W; i++) t = lfsr_step(t);
    return t;
  endfunction

  function automatic slot_t slot_pick(input logic [SLOTS*SLOT_W-1:0] w,
                                      input logic [1:0] k);
    return slot_t'(w[k*SLOT_W +: SLOT_W]);
  endfunction

  // Bernoulli trial: magnitude padded with a leading zero caps p at 1/2
  function automatic logic trial_pass(input logic [DRAW_W-1:0] d,
                                      input logic [MAG_W-1:0] m);
    return d < {1'b0, m};
  endfunction

  function automatic logic [31:0] target_hash(input logic [31:0] g,
                                              input logic [31:0] mul,
                                              input logic [31:0] add);
    return g * mul + add;
  endfunction

endpackage

// File: rtl/sfr_lfsr.sv
module sfr_lfsr import sfr_pkg::*; #(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [DRAW_W-1:0] draw
);
  localparam logic [LFSR_W-1:0] INIT = (SEED == '0) ? LFSR_W'(1) : SEED;

  logic [LFSR_W-1:0] st_q;
  logic [LFSR_W-1:0] st_nxt;

  assign st_nxt = lfsr_jump(st_q);
  assign draw   = st_nxt[DRAW_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)   st_q <= INIT;
    else if (adv) st_q <= st_nxt;
  end

  // R3: a zero state would freeze every later draw
  p_state_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);

endmodule

// File: rtl/sfr_trial.sv
module sfr_trial import sfr_pkg::*; (
  input  slot_t             slot,
  input  logic [DRAW_W-1:0] draw,
  output logic              hit,
  output logic              inh,
  output logic              stop
);
  assign hit  = trial_pass(draw, slot.mag);
  assign inh  = slot.neg;
  assign stop = slot.stop;
endmodule

// File: rtl/sfr_packer.sv
module sfr_packer #(
  parameter int ROUTE_W  = 4,
  parameter int PKT_B    = 5,
  parameter int OUT_W    = 5,
  parameter int WORD_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ROUTE_W-1:0] ld_route,
  input  logic [PKT_B-1:0]   ld_tail,
  output logic               busy,
  output logic               done,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_data,
  output logic               out_last
);
  localparam int PACE_W = $clog2(WORD_CYC) + 1;
  localparam logic [PACE_W-1:0] PACE_LD = PACE_W'(WORD_CYC - 1);
  localparam logic [PACE_W-1:0] PACE_MIN = PACE_W'(WORD_CYC);

  logic               busy_q;
  logic               wsel_q;
  logic [ROUTE_W-1:0] route_q;
  logic [PKT_B-1:0]   tail_q;
  logic [PACE_W-1:0]  pace_q;
  logic               hs;

  assign busy      = busy_q;
  assign out_valid = busy_q && (pace_q == '0);
  assign hs        = out_valid && out_ready;
  assign done      = hs && wsel_q;
  assign out_last  = wsel_q;
  assign out_data  = wsel_q ? OUT_W'(tail_q) : OUT_W'(route_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wsel_q  <= 1'b0;
      route_q <= '0;
      tail_q  <= '0;
      pace_q  <= '0;
    end else begin
      if (hs)                pace_q <= PACE_LD;
      else if (pace_q != '0) pace_q <= pace_q - 1'b1;
      if (load && !busy_q) begin
        busy_q  <= 1'b1;
        wsel_q  <= 1'b0;
        route_q <= ld_route;
        tail_q  <= ld_tail;
      end else if (hs) begin
        if (wsel_q) busy_q <= 1'b0;
        wsel_q <= !wsel_q;
      end
    end
  end

  // checker-side count of cycles since the last handshake
  logic [PACE_W-1:0] since_q;
  logic              seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (hs) begin
      since_q <= PACE_W'(1);
      seen_q  <= 1'b1;
    end else if (since_q < PACE_MIN) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R9: a stalled word holds
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R10: word spacing on the output link
  p_pace_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hs && seen_q |-> since_q >= PACE_MIN);

endmodule

// File: rtl/spike_fanout_router.sv
module spike_fanout_router import sfr_pkg::*; #(
  parameter int CHIP_W   = 1,
  parameter int ROW_W    = 2,
  parameter int COL_W    = 2,
  parameter int ENTRIES  = 4,
  parameter int ROUTE_W  = 4,
  parameter int WORD_CYC = 4,
  parameter logic [31:0] TGT_MUL = 32'd37,
  parameter logic [31:0] TGT_ADD = 32'd11,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int SRC_W  = CHIP_W + ROW_W + COL_W,
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int ADDR_W = SRC_W + ENT_W,
  localparam int PKT_B  = 1 + ROW_W + COL_W,
  localparam int OUT_W  = (ROUTE_W > PKT_B) ? ROUTE_W : PKT_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  in_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_last
);
  localparam int TGT_W = ROUTE_W + ROW_W + COL_W;
  localparam logic [ENT_W-1:0] ENT_LAST = ENT_W'(ENTRIES - 1);

  walk_st_e st_q, st_d;
  logic [SRC_W-1:0] src_q;
  logic [ENT_W-1:0] ent_q;
  logic [1:0]       slot_q;
  logic [31:0]      word_q;
  logic             last_q;

  // named internal events
  logic accept, trial_en, hit, hit_inh, end_mark, final_slot, walk_end;
  logic step_now, pk_busy, pk_done, pk_load;
  logic [DRAW_W-1:0] draw;
  slot_t             cur_slot;
  logic [TGT_W-1:0]  tgt;

  assign in_ready   = (st_q == ST_IDLE);
  assign accept     = in_valid && in_ready;
  assign trial_en   = (st_q == ST_TRIAL);
  assign mem_rd_en  = (st_q == ST_READ);
  assign mem_addr   = {src_q, ent_q};
  assign cur_slot   = slot_pick(word_q, slot_q);
  assign final_slot = (slot_q == 2'd3) && (ent_q == ENT_LAST);
  assign walk_end   = end_mark || final_slot;
  assign pk_load    = trial_en && hit;
  assign step_now   = (trial_en && !hit && !walk_end) ||
                      ((st_q == ST_EMIT) && pk_done && !last_q);
  assign tgt        = TGT_W'(target_hash(32'({src_q, ent_q, slot_q}), TGT_MUL, TGT_ADD));

  sfr_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (trial_en),
    .draw (draw)
  );

  sfr_trial u_trial (
    .slot(cur_slot),
    .draw(draw),
    .hit (hit),
    .inh (hit_inh),
    .stop(end_mark)
  );

  sfr_packer #(
    .ROUTE_W (ROUTE_W),
    .PKT_B   (PKT_B),
    .OUT_W   (OUT_W),
    .WORD_CYC(WORD_CYC)
  ) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pk_load),
    .ld_route (tgt[TGT_W-1 -: ROUTE_W]),
    .ld_tail  ({hit_inh, tgt[ROW_W+COL_W-1:0]}),
    .busy     (pk_busy),
    .done     (pk_done),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_READ;
      ST_READ:  st_d = ST_LOAD;
      ST_LOAD:  st_d = ST_TRIAL;
      ST_TRIAL: begin
        if (hit)           st_d = ST_EMIT;
        else if (walk_end) st_d = ST_IDLE;
        else               st_d = (slot_q == 2'd3) ? ST_READ : ST_TRIAL;
      end
      ST_EMIT: begin
        if (pk_done) begin
          if (last_q) st_d = ST_IDLE;
          else        st_d = (slot_q == 2'd3) ? ST_READ : ST_TRIAL;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      ent_q  <= '0;
      slot_q <= '0;
      word_q <= '0;
      last_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        src_q <= in_data;
        ent_q <= '0;
      end
      if (st_q == ST_LOAD) begin
        word_q <= mem_rd_data;
        slot_q <= '0;
      end
      if (pk_load) last_q <= walk_end;
      if (step_now) begin
        if (slot_q == 2'd3) ent_q  <= ent_q + 1'b1;
        else                slot_q <= slot_q + 1'b1;
      end
    end
  end

  // checker-side count of reads in the current walk
  logic [ENT_W:0] rd_seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         rd_seen_q <= '0;
    else if (accept)    rd_seen_q <= '0;
    else if (mem_rd_en) rd_seen_q <= rd_seen_q + 1'b1;
  end

  // R1: reads walk the entry offsets in rising order, never past the list
  p_read_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr[ENT_W-1:0] == rd_seen_q[ENT_W-1:0]) &&
                  (rd_seen_q < (ENT_W+1)'(ENTRIES)));

  // R8: the input closes as soon as a spike is taken
  p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R7: no read is issued while a packet is still leaving
  p_no_read_in_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pk_busy |-> !mem_rd_en);

endmodule

// File: tb/sim_spike_fanout_router.sv
`timescale 1ns/1ps
module sim_spike_fanout_router;
  localparam int CHIP_W = 1, ROW_W = 2, COL_W = 2, ENTRIES = 4, ROUTE_W = 4, WORD_CYC = 4;
  localparam int SRC_W = CHIP_W + ROW_W + COL_W;
  localparam int ADDR_W = SRC_W + 2;
  localparam int NSRC = 1 << SRC_W;
  localparam int MEM_N = 1 << ADDR_W;
  localparam int OUT_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 1'b0, in_ready;
  logic [SRC_W-1:0] in_data = '0;
  logic mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_rd_data;
  logic out_valid, out_ready = 1'b0, out_last;
  logic [OUT_W-1:0] out_data;

  spike_fanout_router u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  logic [31:0] mem [MEM_N];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench model of the random source
  logic [15:0] m_s = 16'hACE1;
  function automatic int next_draw();
    for (int i = 0; i < 7; i++) m_s = {m_s[14:0], ^(m_s & 16'hB400)};
    return int'(m_s[6:0]);
  endfunction

  int exp_w [64];
  bit exp_l [64];
  int head = 0, tail = 0;
  int exp_base = 0, rd_cnt = 0, exp_reads = 0;
  int pkt_cnt = 0;

  task automatic model_walk(input int src);
    bit done = 0;
    exp_reads = 0;
    for (int e = 0; e < ENTRIES && !done; e++) begin
      int a = src * ENTRIES + e;
      exp_reads++;
      for (int k = 0; k < 4 && !done; k++) begin
        int b = int'((mem[a] >> (8 * k)) & 32'hFF);
        int d = next_draw();
        if (d < (b & 63)) begin
          int t = ((a * 4 + k) * 37 + 11) & 255;
          exp_w[tail] = t >> 4;  exp_l[tail] = 1'b0; tail++;
          exp_w[tail] = (((b >> 6) & 1) << 4) | (t & 15); exp_l[tail] = 1'b1; tail++;
        end
        if (b[7]) done = 1;
      end
    end
  endtask

  int rdy_mode = 0, pat = 0;
  initial forever begin
    @(posedge clk); #1; pat++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (pat % 3) != 0;
      default: out_ready = (pat % 7) < 2;
    endcase
  end

  int cyc = 0, last_hs = -100;
  bit prev_stall = 0;
  logic [OUT_W-1:0] prev_data;
  bit prev_last;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data && out_last == prev_last, "R9", "stalled word held", int'(out_data), int'(prev_data));
      if (mem_rd_en) begin
        chk(int'(mem_addr) == exp_base + rd_cnt, "R1", "read address", int'(mem_addr), exp_base + rd_cnt);
        rd_cnt++;
      end
      if (head < tail) chk(!in_ready, "R8", "ready low during walk", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        chk(cyc - last_hs >= WORD_CYC, "R10", "word spacing", cyc - last_hs, WORD_CYC);
        last_hs = cyc;
        if (head >= tail) chk(0, "R4", "unexpected word", int'(out_data), -1);
        else begin
          chk(int'(out_data) == exp_w[head], exp_l[head] ? "R6" : "R5", "word value", int'(out_data), exp_w[head]);
          chk(out_last == exp_l[head], "R12", "word order / last flag", int'(out_last), int'(exp_l[head]));
          head++;
        end
        if (out_last) pkt_cnt++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
      prev_last = out_last;
    end
  end

  task automatic send_spike(input int src);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = SRC_W'(src);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    head = 0; tail = 0; rd_cnt = 0; exp_base = src * ENTRIES;
    model_walk(src);
    @(negedge clk);
    chk(!in_ready, "R8", "ready after accept", int'(in_ready), 0);
    while (!(in_ready && head == tail)) @(negedge clk);
    chk(rd_cnt == exp_reads, "R7", "reads per walk", rd_cnt, exp_reads);
  endtask

  function automatic logic [31:0] fill_word(input int a, input int pass);
    logic [31:0] w;
    w = (32'(a) + 1) * 32'h9E3779B1 ^ (32'(pass) * 32'h7F4A7C15);
    w = w & 32'h7F7F7F7F;
    for (int k = 0; k < 4; k++) if ((a * 4 + k + pass) % 11 == 0) w[8*k+7] = 1'b1;
    return w;
  endfunction

  task automatic fill_all(input int pass);
    for (int a = 0; a < MEM_N; a++) mem[a] = fill_word(a, pass);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "R7", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int base_pkts;
    fill_all(0);
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && !mem_rd_en, "R11", "idle outputs in reset", int'({in_ready, out_valid, mem_rd_en}), 4);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !mem_rd_en, "R11", "idle outputs after reset", int'({in_ready, out_valid, mem_rd_en}), 4);

    // R2 R3 R5: full sweeps, three back-pressure patterns
    for (int m = 0; m < 3; m++) begin
      rdy_mode = m;
      if (m == 2) fill_all(1);
      for (int s = 0; s < NSRC; s++) send_spike(s);
    end

    // R4: zero magnitudes never deliver
    rdy_mode = 0;
    for (int e = 0; e < ENTRIES; e++) mem[3 * ENTRIES + e] = 32'h40004000;
    base_pkts = pkt_cnt;
    for (int i = 0; i < 20; i++) send_spike(3);
    chk(pkt_cnt == base_pkts, "R4", "zero weight packets", pkt_cnt - base_pkts, 0);

    // R7: end mark on the very first slot, then in entry 1 slot 2
    mem[5 * ENTRIES] = 32'h3F3F3FA8;
    for (int i = 0; i < 4; i++) send_spike(5);
    chk(rd_cnt == 1, "R7", "single read for early end", rd_cnt, 1);
    mem[6 * ENTRIES] = 32'h3F3F3F3F;
    mem[6 * ENTRIES + 1] = 32'h3FBF3F3F;
    for (int i = 0; i < 4; i++) send_spike(6);
    chk(rd_cnt == 2, "R7", "two reads for end in entry 1", rd_cnt, 2);

    // R4 R6: saturated weights with alternating sign, delivery rate
    rdy_mode = 1;
    for (int e = 0; e < ENTRIES; e++) mem[7 * ENTRIES + e] = 32'h7F3F7F3F;
    base_pkts = pkt_cnt;
    for (int i = 0; i < 150; i++) send_spike(7);
    chk(pkt_cnt - base_pkts >= 1060 && pkt_cnt - base_pkts <= 1305, "R4", "weight 63 hits in 2400 trials", pkt_cnt - base_pkts, 1181);

    repeat (5) @(negedge clk);
    chk(in_ready && !out_valid, "R8", "idle at end", int'({in_ready, out_valid}), 2);
    finish_run();
  end
endmodule